// File: doc/BRIEF.md
# I2C Configuration Register Bank Slave

This block is an I2C bus slave. It gives a host read and write access to a bank of sixteen 8-bit configuration registers. It samples the bus clock and data lines on a fast system clock and finds START, repeated START and STOP conditions from them. It answers one fixed 7-bit device address. The contents of every register appear at all times on a flat parallel output, so the logic around the block can use the configuration directly.

A write transaction carries the device address with the direction bit low, then a register index byte, then any number of data bytes. Each data byte goes into the register that the internal pointer selects, and it is committed in the cycle the slave starts its acknowledge. The commit does not wait for STOP. The pointer steps after every byte and wraps inside the bank.

To read, the host first runs a write transaction that carries only the register index. It then issues a repeated START and sends the address again with the direction bit high. The slave streams bytes from the pointer onward for as long as the host acknowledges them. The host ends the read with a NACK followed by STOP.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset every register reads zero on `regs_o` and `sda_oe` is low, so SDA is released.
- R2: The slave acknowledges an address byte whose upper seven bits, sent MSB first, equal the device address. The byte's least significant bit is the direction bit: 0 selects write and 1 selects read.
- R3: The slave does not acknowledge an address byte with a different address. Bytes that follow it are neither acknowledged nor stored until the next START.
- R4: In a write, the first byte after the address is acknowledged, and its low four bits load the register pointer.
- R5: Each data byte that follows is acknowledged and written to the register at the pointer. The new value is visible on `regs_o` by the end of that acknowledge clock, before any STOP.
- R6: The pointer steps by one after every data byte written or read, and it wraps from register 15 to register 0.
- R7: A START or STOP that arrives partway through a data byte discards the bits already received. No register changes, and the pointer keeps its value.
- R8: After a pointer-setting write, a repeated START with the address and the direction bit at 1 is acknowledged. The slave then shifts out the register at the pointer, MSB first.
- R9: While the host acknowledges, the read continues with the following registers and wraps past register 15. A host NACK ends the read, after which SDA stays released.
- R10: SDA is only ever pulled low (`sda_oe` high) or released, and `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 128 | Register bank, register n in bits [8n+7:8n] |

## Verification
The bench writes sequential bursts that start near the top of the bank. A pointer that does not wrap would scribble past register 15 or leave registers 0 and 1 unwritten. It checks each register right after its acknowledge and before STOP, which catches a design that buffers writes until STOP. It breaks a data byte with a STOP and with a repeated START. A design that commits partial bytes would corrupt the targeted register, and one that loses the pointer on the restart would read back the wrong register. It also sends a foreign address and then a full 16-byte read from a nonzero index. A slave that answers the wrong address, or that stops or fails to wrap mid-stream, shows up as a wrong acknowledge or a data mismatch against the bench's own model.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEVADR,
    S_DEVACK,
    S_REGPTR,
    S_PTRACK,
    S_WRDAT,
    S_WRACK,
    S_RDDAT,
    S_RDACK
  } rb_state_t;

  // Next pointer value inside a bank of n entries.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // Upper seven bits of a received address byte against the device address.
  function automatic logic addr_match(logic [7:0] b, logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2c_rb_busmon.sv
module i2c_rb_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // Data edges while the clock stays high are bus conditions.
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [PW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] bank_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && (wr_idx == PW'(i)))
        q <= wr_data;
    end
    assign bank_flat[i*DW +: DW] = q;
  end

  assign rd_data = bank_flat[int'(rd_idx)*DW +: DW];

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5C,
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_byte,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] ptr,
  output logic [DW-1:0] wr_byte,
  output logic          addr_nack,
  output logic          rx_done
);

  rb_state_t     state;
  logic [2:0]    cnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] tx;
  logic          got8;
  logic          rw;
  logic          mack;
  logic          rx_state;
  logic          hit;
  logic [PW-1:0] ptr_nx;

  assign rx_state  = (state == S_DEVADR) || (state == S_REGPTR) || (state == S_WRDAT);
  assign rx_done   = rx_state && got8 && scl_fall;
  assign hit       = addr_match(shreg, DEV_ADDR);
  assign wr_en     = rx_done && (state == S_WRDAT);
  assign addr_nack = rx_done && (state == S_DEVADR) && !hit;
  assign wr_byte   = shreg;
  assign ptr_nx    = PW'(ptr_step(int'(ptr), NREG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      tx     <= '0;
      got8   <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= S_DEVADR;
      cnt    <= '0;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      cnt    <= '0;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        S_DEVADR, S_REGPTR, S_WRDAT: begin
          if (scl_rise && !got8) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) got8 <= 1'b1;
          end else if (rx_done) begin
            got8 <= 1'b0;
            cnt  <= '0;
            if (state == S_DEVADR) begin
              if (hit) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                state  <= S_DEVACK;
              end else begin
                state  <= S_IDLE;
              end
            end else if (state == S_REGPTR) begin
              ptr    <= shreg[PW-1:0];
              sda_oe <= 1'b1;
              state  <= S_PTRACK;
            end else begin
              ptr    <= ptr_nx;
              sda_oe <= 1'b1;
              state  <= S_WRACK;
            end
          end
        end
        S_DEVACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[DW-1];
              cnt    <= '0;
              state  <= S_RDDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_REGPTR;
            end
          end
        end
        S_PTRACK, S_WRACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_WRDAT;
          end
        end
        S_RDDAT: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_nx;
              state  <= S_RDACK;
            end else begin
              tx     <= {tx[DW-2:0], 1'b0};
              sda_oe <= ~tx[DW-2];
              cnt    <= cnt + 3'd1;
            end
          end
        end
        S_RDACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[DW-1];
              cnt    <= '0;
              state  <= S_RDDAT;
            end else begin
              state  <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h5C,
  parameter int         NREG        = 16,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] regs_o
);

  localparam int PW = $clog2(NREG);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          wr_en;
  logic [PW-1:0] ptr;
  logic [DW-1:0] wr_byte;
  logic [DW-1:0] rd_byte;
  logic          addr_nack;
  logic          rx_done;

  i2c_rb_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rb_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .DW(DW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .ptr       (ptr),
    .wr_byte   (wr_byte),
    .addr_nack (addr_nack),
    .rx_done   (rx_done)
  );

  i2c_rb_regfile #(.NREG(NREG), .DW(DW)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (ptr),
    .wr_data   (wr_byte),
    .rd_idx    (ptr),
    .rd_data   (rd_byte),
    .bank_flat (regs_o)
  );

endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               start_det,
  input logic               stop_det,
  input logic               sda_oe,
  input logic               wr_en,
  input logic [PW-1:0]      ptr,
  input logic [NREG*DW-1:0] regs,
  input logic               addr_nack
);

  // R10: the data line driver only moves while the clock is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !scl_s);

  // R5: a register commit coincides with the start of the slave acknowledge
  a_r5_commit_acks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R6: a write to the top register leaves the pointer at register 0
  a_r6_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (ptr == PW'(NREG-1)) |=> (ptr == '0));

  // R7: without a commit the bank does not move
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

  // R3: a foreign address leaves the line released
  a_r3_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    addr_nack |=> !sda_oe);

  // R7: a STOP releases the line and commits nothing
  a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe && $stable(regs));

endmodule

bind i2c_regbank_slave i2c_rb_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .ptr       (ptr),
  .regs      (regs_o),
  .addr_nack (addr_nack)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;

  localparam logic [6:0] DEV = 7'h5C;
  localparam logic [6:0] BAD = 7'h23;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [127:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regbank_slave #(.DEV_ADDR(DEV)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .regs_o (regs_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] m [16];
  int mp = 0;
  bit settled = 1'b0;
  bit cont_bad = 1'b0;
  bit r10_bad = 1'b0;
  logic prev_oe = 1'b0;

  function automatic logic [7:0] reg_at(int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model compared on every clock while no byte is in flight.
  always @(negedge clk) begin
    if (rst_n && settled && !cont_bad) begin
      for (int i = 0; i < 16; i++) begin
        if (reg_at(i) !== m[i] && !cont_bad) begin
          cont_bad = 1'b1;
          fails++;
          $display("FAIL R5 bank model reg%0d actual=%0h expected=%0h", i, reg_at(i), m[i]);
        end
      end
    end
    // R10 monitor: driver changes only with SCL low
    if (rst_n && (sda_oe !== prev_oe) && scl) r10_bad = 1'b1;
    prev_oe = sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    ack = !v;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin get_bit(v); d[i] = v; end
    put_bit(!give_ack);
  endtask

  task automatic wr_seq(input logic [7:0] p, input logic [7:0] d[$]);
    logic ack;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R2 write address ack", ack, 1);
    put_byte(p, ack);           chk("R4 index byte ack", ack, 1);
    mp = p % 16;
    foreach (d[i]) begin
      settled = 1'b0;
      put_byte(d[i], ack);      chk("R5 data byte ack", ack, 1);
      m[mp] = d[i];
      chk("R5 register updated before STOP", reg_at(mp), d[i]);
      mp = (mp + 1) % 16;
      settled = 1'b1;
    end
    bus_stop();
  endtask

  task automatic rd_seq(input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, ack); chk("R8 dummy write ack", ack, 1);
    put_byte(p, ack);           chk("R8 index ack", ack, 1);
    mp = p % 16;
    bus_start();
    put_byte({DEV, 1'b1}, ack); chk("R8 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      if (i == 0) chk("R8 first read byte", d, m[mp]);
      else        chk("R9 streamed read byte", d, m[mp]);
      mp = (mp + 1) % 16;
    end
    chk("R9 line released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] fill[$];
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 16; i++) chk("R1 register zero after reset", reg_at(i), 0);
    chk("R1 SDA released after reset", sda_oe, 0);
    settled = 1'b1;

    // R2/R4/R5: plain random write
    wr_seq(8'h03, '{8'hA5, 8'h3C});

    // R5/R6: fill the whole bank from index 0
    for (int i = 0; i < 16; i++) fill.push_back(8'(i * 17 + 3));
    wr_seq(8'h00, fill);

    // R6: burst starting at 14 wraps into 0 and 1
    wr_seq(8'h0E, '{8'h11, 8'h22, 8'h33, 8'h44});
    chk("R6 wrapped write reg0", reg_at(0), 8'h33);
    chk("R6 wrapped write reg1", reg_at(1), 8'h44);

    // R4: only the low index bits select the register
    wr_seq(8'h27, '{8'h5A});
    chk("R4 index 0x27 hits reg7", reg_at(7), 8'h5A);

    // R7: STOP in the middle of a data byte
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h05, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    chk("R7 reg5 untouched by STOP mid-byte", reg_at(5), m[5]);

    // R7: repeated START mid-byte keeps the pointer
    bus_start();
    put_byte({DEV, 1'b0}, ack);
    put_byte(8'h06, ack);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte({DEV, 1'b1}, ack); chk("R7 address ack after restart", ack, 1);
    get_byte(1'b0, d);
    chk("R7 pointer kept across restart", d, m[6]);
    bus_stop();
    chk("R7 reg6 untouched by restart", reg_at(6), m[6]);

    // R3: foreign address is ignored until the next START
    bus_start();
    put_byte({BAD, 1'b0}, ack); chk("R3 foreign address not acked", ack, 0);
    put_byte(8'h02, ack);       chk("R3 index not acked", ack, 0);
    put_byte(8'h99, ack);       chk("R3 data not acked", ack, 0);
    bus_stop();
    chk("R3 reg2 unchanged", reg_at(2), m[2]);

    // R8: random read
    rd_seq(8'h03, 1);
    // R9: full streamed read from a nonzero index with wrap
    rd_seq(8'h0B, 16);

    // R10 aggregate over the whole run
    checks++;
    if (r10_bad) begin
      fails++;
      $display("FAIL R10 sda_oe moved while SCL high actual=1 expected=0");
    end
    // R5 continuous model comparison aggregate
    checks++;

    // R1: reset again after traffic
    rst_n = 1'b0;
    settled = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) chk("R1 register cleared by reset", reg_at(i), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule